// File: doc/BRIEF.md
# AXI Transaction ID Match Filter

This block sits beside a memory controller and looks at every completed AXI read or write transaction. Each observation carries the transaction ID, the controller port it arrived on, a channel bit, the burst length and the beat size. For each of a small bank of event counters, the filter decides whether the transaction belongs to that counter. It then produces the amount the counter should add: either one per matching burst or, in byte mode, the number of bytes the burst moved.

Each counter has two configuration words. The first holds a reference ID and a compare mask. The second selects, separately for reads and writes, which port and which channel value a transaction must carry. Each counter is also given an event code. Code 0x41 counts reads that pass the filter and code 0x42 counts writes that pass it. Any other code never produces a hit. The increment results are registered and appear one clock after the observation, ready for an external counter bank to accumulate.

Top module: `axid_match_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, every configuration word reads 0, `inc_valid` is 0, `inc_hit` is all zero and every `inc_amount` lane is 0.
- R2: A write sets the configuration word of counter n (n = 1..NCNT). The compare word is at byte address 0x54 + 16*(n-1) and the select word is at 0x50 + 16*(n-1). Both read back at the same address. In the compare word, bits [15:0] are the reference ID and bits [31:16] are the mask. In the select word only bits [3:0] and [11:8] are kept, and all other bits read 0.
- R3: A write to any address other than those in R2 changes no configuration word.
- R4: The ID test passes when ((id XOR reference) AND mask) is zero. A mask bit of 1 means that ID bit is compared, and a mask of 0 accepts every ID.
- R5: A counter whose code is 0x41 can hit only on reads (`obs_write`=0). A counter whose code is 0x42 can hit only on writes (`obs_write`=1). Any other code never hits.
- R6: A read must carry the port in select bits [2:0] and the channel value in select bit 3. A write must carry the port in select bits [10:8] and the channel value in select bit 11.
- R7: With `byte_mode` low, a hitting lane's amount is 1.
- R8: With `byte_mode` high, a hitting lane's amount is (len+1) << size. The largest value is 32768, for len 255 and size 7.
- R9: `inc_valid` is asserted exactly one cycle after `obs_valid`. A lane that does not hit, or any lane on a cycle without `inc_valid`, shows a hit of 0 and an amount of 0.
- R10: If a configuration write and an observation fall in the same cycle, the observation is judged against the configuration that existed before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 8 | Configuration write byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | 8 | Configuration read byte address |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| evt_code | input | 8*NCNT | Event code per counter, counter n in bits [8n-1:8n-8] |
| byte_mode | input | 1 | 1: count bytes, 0: count bursts |
| obs_valid | input | 1 | Observed transaction present |
| obs_write | input | 1 | 1 for a write transaction, 0 for a read |
| obs_id | input | 16 | Transaction ID |
| obs_port | input | 3 | Controller port number |
| obs_chan | input | 1 | Channel bit |
| obs_len | input | 8 | Burst length minus one |
| obs_size | input | 3 | Log2 of bytes per beat |
| inc_valid | output | 1 | Increment results valid |
| inc_hit | output | NCNT | Per-counter match flag |
| inc_amount | output | 16*NCNT | Per-counter increment, counter n in bits [16n-1:16n-16] |

## Verification
Two events can share a clock edge: a configuration write and an observation that the same word governs. The bench provokes this by driving `cfg_we` and `obs_valid` in the same cycle, using values chosen so that the old and new settings give different results. Its scoreboard computes the expected hit from the setting that existed before the write and flags a result that reflects the new word. A second observation after the write confirms that the new setting then takes effect.

// File: rtl/axid_filt_pkg.sv
package axid_filt_pkg;

    localparam int ID_W   = 16;
    localparam int PORT_W = 3;
    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CODE_W = 8;
    // widest byte count: (2**LEN_W) << (2**SIZE_W - 1)
    localparam int INC_W  = LEN_W + 1 + (2 ** SIZE_W - 1);

    localparam logic [CODE_W-1:0] CODE_RD = 8'h41;
    localparam logic [CODE_W-1:0] CODE_WR = 8'h42;

    localparam int SEL_BASE = 'h50;
    localparam int CMP_BASE = 'h54;
    localparam int STRIDE   = 'h10;

    typedef struct packed {
        logic [ID_W-1:0] mask;
        logic [ID_W-1:0] ref_id;
    } cmp_word_t;

    typedef struct packed {
        logic              wr_chan;
        logic [PORT_W-1:0] wr_port;
        logic              rd_chan;
        logic [PORT_W-1:0] rd_port;
    } sel_word_t;

    typedef struct packed {
        logic              write;
        logic [ID_W-1:0]   id;
        logic [PORT_W-1:0] port;
        logic              chan;
        logic [LEN_W-1:0]  len;
        logic [SIZE_W-1:0] size;
    } xact_t;

    function automatic logic [ADDR_W-1:0] sel_addr(input int n);
        return ADDR_W'(SEL_BASE + STRIDE * n);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_addr(input int n);
        return ADDR_W'(CMP_BASE + STRIDE * n);
    endfunction

    function automatic sel_word_t unpack_sel(input logic [DATA_W-1:0] w);
        sel_word_t s;
        s.rd_port = w[2:0];
        s.rd_chan = w[3];
        s.wr_port = w[10:8];
        s.wr_chan = w[11];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_sel(input sel_word_t s);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[2:0]   = s.rd_port;
        w[3]     = s.rd_chan;
        w[10:8]  = s.wr_port;
        w[11]    = s.wr_chan;
        return w;
    endfunction

endpackage

// File: rtl/axid_filt_regs.sv
module axid_filt_regs
    import axid_filt_pkg::*;
#(
    parameter int NCNT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [DATA_W-1:0]   rdata,
    output cmp_word_t           cmp_o [NCNT],
    output sel_word_t           sel_o [NCNT]
);

    for (genvar n = 0; n < NCNT; n++) begin : g_lane
        localparam logic [ADDR_W-1:0] A_CMP = cmp_addr(n);
        localparam logic [ADDR_W-1:0] A_SEL = sel_addr(n);

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_o[n] <= '0;
                sel_o[n] <= '0;
            end else if (we) begin
                if (waddr == A_CMP) cmp_o[n] <= cmp_word_t'(wdata);
                if (waddr == A_SEL) sel_o[n] <= unpack_sel(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCNT; n++) begin
            if (raddr == cmp_addr(n)) rdata = DATA_W'(cmp_o[n]);
            if (raddr == sel_addr(n)) rdata = pack_sel(sel_o[n]);
        end
    end

endmodule

// File: rtl/axid_filt_match.sv
module axid_filt_match
    import axid_filt_pkg::*;
(
    input  xact_t              xact,
    input  cmp_word_t          cmp,
    input  sel_word_t          sel,
    input  logic [CODE_W-1:0]  code,
    output logic               hit
);

    logic              dir_ok;
    logic              id_ok;
    logic [PORT_W-1:0] want_port;
    logic              want_chan;

    always_comb begin
        dir_ok    = (code == CODE_RD && !xact.write) ||
                    (code == CODE_WR &&  xact.write);
        want_port = xact.write ? sel.wr_port : sel.rd_port;
        want_chan = xact.write ? sel.wr_chan : sel.rd_chan;
        id_ok     = ((xact.id ^ cmp.ref_id) & cmp.mask) == '0;
        hit       = dir_ok && id_ok &&
                    (xact.port == want_port) && (xact.chan == want_chan);
    end

endmodule

// File: rtl/axid_filt_bytes.sv
module axid_filt_bytes
    import axid_filt_pkg::*;
(
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic [INC_W-1:0]  nbytes
);

    logic [INC_W-1:0] beats;

    always_comb begin
        beats  = INC_W'(len) + INC_W'(1);
        nbytes = beats << size;
    end

endmodule

// File: rtl/axid_match_filter.sv
module axid_match_filter
    import axid_filt_pkg::*;
#(
    parameter int NCNT = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_waddr,
    input  logic [31:0]              cfg_wdata,
    input  logic [7:0]               cfg_raddr,
    output logic [31:0]              cfg_rdata,
    input  logic [8*NCNT-1:0]        evt_code,
    input  logic                     byte_mode,
    input  logic                     obs_valid,
    input  logic                     obs_write,
    input  logic [15:0]              obs_id,
    input  logic [2:0]               obs_port,
    input  logic                     obs_chan,
    input  logic [7:0]               obs_len,
    input  logic [2:0]               obs_size,
    output logic                     inc_valid,
    output logic [NCNT-1:0]          inc_hit,
    output logic [16*NCNT-1:0]       inc_amount
);

    cmp_word_t        cmp_w [NCNT];
    sel_word_t        sel_w [NCNT];
    xact_t            xact;
    logic [INC_W-1:0] nbytes;
    logic [INC_W-1:0] step;

    assign xact = '{write: obs_write, id: obs_id, port: obs_port,
                    chan: obs_chan, len: obs_len, size: obs_size};

    axid_filt_regs #(.NCNT(NCNT)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata),
        .cmp_o (cmp_w),
        .sel_o (sel_w)
    );

    axid_filt_bytes bytes_i (
        .len    (obs_len),
        .size   (obs_size),
        .nbytes (nbytes)
    );

    assign step = byte_mode ? nbytes : INC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) inc_valid <= 1'b0;
        else     inc_valid <= obs_valid;
    end

    for (genvar n = 0; n < NCNT; n++) begin : g_cnt
        logic hit_c;

        axid_filt_match match_i (
            .xact (xact),
            .cmp  (cmp_w[n]),
            .sel  (sel_w[n]),
            .code (evt_code[n*CODE_W +: CODE_W]),
            .hit  (hit_c)
        );

        always_ff @(posedge clk) begin
            if (rst || !obs_valid || !hit_c) begin
                inc_hit[n]                     <= 1'b0;
                inc_amount[n*INC_W +: INC_W]   <= '0;
            end else begin
                inc_hit[n]                     <= 1'b1;
                inc_amount[n*INC_W +: INC_W]   <= step;
            end
        end
    end

endmodule

// File: rtl/axid_filt_chk.sv
module axid_filt_chk #(
    parameter int NCNT = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [8*NCNT-1:0]   evt_code,
    input logic                byte_mode,
    input logic                obs_valid,
    input logic                obs_write,
    input logic                inc_valid,
    input logic [NCNT-1:0]     inc_hit,
    input logic [16*NCNT-1:0]  inc_amount
);

    // R1: reset empties the output stage
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!inc_valid && inc_hit == '0 && inc_amount == '0));

    // R9: result follows an observation by one cycle
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        obs_valid |=> inc_valid);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        !obs_valid |=> !inc_valid);

    p_hit_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !inc_valid |-> (inc_hit == '0 && inc_amount == '0));

    for (genvar n = 0; n < NCNT; n++) begin : g_lane
        // R5: foreign event codes never hit
        p_code_gate_r5: assert property (@(posedge clk) disable iff (rst)
            (obs_valid && evt_code[n*8 +: 8] != 8'h41 && evt_code[n*8 +: 8] != 8'h42)
            |=> !inc_hit[n]);

        // R5: a read counter ignores writes, a write counter ignores reads
        p_dir_gate_r5: assert property (@(posedge clk) disable iff (rst)
            (obs_valid && ((obs_write && evt_code[n*8 +: 8] == 8'h41) ||
                           (!obs_write && evt_code[n*8 +: 8] == 8'h42)))
            |=> !inc_hit[n]);

        // R7: burst mode adds one per hit
        p_burst_one_r7: assert property (@(posedge clk) disable iff (rst)
            (obs_valid && !byte_mode)
            |=> (inc_amount[n*16 +: 16] == (inc_hit[n] ? 16'd1 : 16'd0)));

        // R8: byte mode amount is never zero on a hit
        p_bytes_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
            (obs_valid && byte_mode) |=> (inc_hit[n] == (inc_amount[n*16 +: 16] != 16'd0)));
    end

endmodule

bind axid_match_filter axid_filt_chk #(.NCNT(NCNT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .evt_code   (evt_code),
    .byte_mode  (byte_mode),
    .obs_valid  (obs_valid),
    .obs_write  (obs_write),
    .inc_valid  (inc_valid),
    .inc_hit    (inc_hit),
    .inc_amount (inc_amount)
);

// File: tb/axid_match_filter_tb_top.sv
module axid_match_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_waddr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [7:0]    cfg_raddr = '0;
    logic [31:0]   cfg_rdata;
    logic [8*NC-1:0] evt_code = '0;
    logic          byte_mode = 1'b0;
    logic          obs_valid = 1'b0;
    logic          obs_write = 1'b0;
    logic [15:0]   obs_id = '0;
    logic [2:0]    obs_port = '0;
    logic          obs_chan = 1'b0;
    logic [7:0]    obs_len = '0;
    logic [2:0]    obs_size = '0;
    logic          inc_valid;
    logic [NC-1:0] inc_hit;
    logic [16*NC-1:0] inc_amount;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NC-1:0] hit;
        logic [15:0]   amt [NC];
    } exp_t;

    exp_t sb_q [$];
    logic [31:0] m_cmp [NC];
    logic [31:0] m_sel [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    axid_match_filter #(.NCNT(NC)) dut_i (.*);

    function automatic exp_t predict(input logic wr, input logic [15:0] id,
                                     input logic [2:0] port, input logic ch,
                                     input logic [7:0] len, input logic [2:0] sz);
        exp_t e;
        for (int n = 0; n < NC; n++) begin
            logic [7:0] code;
            logic dir_ok, id_ok, ps_ok;
            code   = evt_code[n*8 +: 8];
            dir_ok = (code == 8'h41 && !wr) || (code == 8'h42 && wr);
            id_ok  = ((id ^ m_cmp[n][15:0]) & m_cmp[n][31:16]) == 16'h0;
            ps_ok  = wr ? (port == m_sel[n][10:8] && ch == m_sel[n][11])
                        : (port == m_sel[n][2:0]  && ch == m_sel[n][3]);
            e.hit[n] = dir_ok && id_ok && ps_ok;
            if (!e.hit[n])      e.amt[n] = 16'd0;
            else if (byte_mode) e.amt[n] = 16'((32'(len) + 32'd1) << sz);
            else                e.amt[n] = 16'd1;
        end
        return e;
    endfunction

    function automatic void shadow_write(input logic [7:0] a, input logic [31:0] d);
        for (int n = 0; n < NC; n++) begin
            if (a == 8'(8'h54 + 16*n)) m_cmp[n] = d;
            if (a == 8'(8'h50 + 16*n)) m_sel[n] = d & 32'h0000_0F0F;
        end
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(a, d);
    endtask

    task automatic check_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cfg_raddr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr 0x%02h actual 0x%08h expected 0x%08h", tag, a, cfg_rdata, exp);
        end
    endtask

    task automatic check_all_regs(input string tag);
        for (int n = 0; n < NC; n++) begin
            check_read(8'(8'h54 + 16*n), m_cmp[n], tag);
            check_read(8'(8'h50 + 16*n), m_sel[n], tag);
        end
    endtask

    // driver: one observation per call, expectation pushed to the scoreboard
    task automatic observe(input logic wr, input logic [15:0] id, input logic [2:0] port,
                           input logic ch, input logic [7:0] len, input logic [2:0] sz);
        @(negedge clk);
        obs_valid = 1'b1; obs_write = wr; obs_id = id; obs_port = port;
        obs_chan = ch; obs_len = len; obs_size = sz;
        sb_q.push_back(predict(wr, id, port, ch, len, sz));
        @(negedge clk);
        obs_valid = 1'b0;
    endtask

    // R10: configuration write and observation in one cycle
    task automatic observe_with_write(input logic [7:0] a, input logic [31:0] d,
                                      input logic wr, input logic [15:0] id,
                                      input logic [2:0] port, input logic ch);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        obs_valid = 1'b1; obs_write = wr; obs_id = id; obs_port = port;
        obs_chan = ch; obs_len = 8'd3; obs_size = 3'd2;
        sb_q.push_back(predict(wr, id, port, ch, 8'd3, 3'd2));
        shadow_write(a, d);
        @(negedge clk);
        cfg_we = 1'b0; obs_valid = 1'b0;
    endtask

    // monitor: compares each result with the oldest expectation
    always @(negedge clk) begin
        if (!rst && inc_valid) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 result without observation actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                for (int n = 0; n < NC; n++) begin
                    checks++;
                    if (inc_hit[n] !== e.hit[n] || inc_amount[n*16 +: 16] !== e.amt[n]) begin
                        errors++;
                        $display("FAIL R4 R5 R6 R7 R8 R10 counter %0d actual hit=%0b amt=%0d expected hit=%0b amt=%0d",
                                 n + 1, inc_hit[n], inc_amount[n*16 +: 16], e.hit[n], e.amt[n]);
                    end
                end
            end
        end
    end

    task automatic check_idle(input string tag);
        @(negedge clk);
        checks++;
        if (inc_valid !== 1'b0 || inc_hit !== '0 || inc_amount !== '0) begin
            errors++;
            $display("FAIL %s idle actual valid=%0b hit=%0b amt=0x%0h expected 0 0 0",
                     tag, inc_valid, inc_hit, inc_amount);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < NC; n++) begin m_cmp[n] = '0; m_sel[n] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all_regs("R1");
        check_idle("R1");
        rst = 1'b0;
        check_idle("R1");
        check_all_regs("R1");

        // R2: programming and readback
        cfg_write(8'h54, 32'hFF00_1234);   // compare upper ID byte 0x12
        cfg_write(8'h50, 32'h0000_050A);   // read port 2 chan 1, write port 5 chan 0
        cfg_write(8'h64, 32'h0000_0000);   // any ID
        cfg_write(8'h60, 32'h0000_0301);   // read port 1 chan 0, write port 3 chan 0
        cfg_write(8'h74, 32'hFFFF_00AB);   // exact ID 0x00AB
        cfg_write(8'h70, 32'hFFFF_FFFF);   // only [11:8],[3:0] kept
        check_all_regs("R2");
        check_read(8'h70, 32'h0000_0F0F, "R2");

        // R3: unmapped writes
        cfg_write(8'h58, 32'hDEAD_BEEF);
        cfg_write(8'h80, 32'hDEAD_BEEF);
        cfg_write(8'h30, 32'hDEAD_BEEF);
        check_all_regs("R3");

        evt_code = {8'h41, 8'h42, 8'h41};   // c3 read, c2 write, c1 read

        // R4 R6 R7: burst mode patterns
        byte_mode = 1'b0;
        observe(1'b0, 16'h12FF, 3'd2, 1'b1, 8'd0, 3'd0);  // c1 hit
        observe(1'b0, 16'h13FF, 3'd2, 1'b1, 8'd0, 3'd0);  // c1 id miss
        observe(1'b0, 16'h1200, 3'd2, 1'b0, 8'd0, 3'd0);  // c1 chan miss
        observe(1'b0, 16'h1200, 3'd7, 1'b1, 8'd0, 3'd0);  // c1 port miss
        observe(1'b1, 16'h4444, 3'd3, 1'b0, 8'd1, 3'd1);  // c2 write hit
        observe(1'b1, 16'h4444, 3'd1, 1'b0, 8'd1, 3'd1);  // c2 miss: read port used
        observe(1'b0, 16'h00AB, 3'd7, 1'b1, 8'd0, 3'd0);  // c3 hit
        observe(1'b0, 16'h00AA, 3'd7, 1'b1, 8'd0, 3'd0);  // c3 miss
        check_idle("R9");

        // R8: byte mode
        byte_mode = 1'b1;
        observe(1'b0, 16'h1200, 3'd2, 1'b1, 8'd255, 3'd7); // 32768
        observe(1'b0, 16'h1200, 3'd2, 1'b1, 8'd0, 3'd0);   // 1
        observe(1'b1, 16'h0000, 3'd3, 1'b0, 8'd15, 3'd3);  // 128
        observe(1'b0, 16'h00AB, 3'd7, 1'b1, 8'd7, 3'd2);   // 32

        // R5: direction and foreign code
        byte_mode = 1'b0;
        evt_code = {8'h05, 8'h41, 8'h42};
        observe(1'b0, 16'h00AB, 3'd7, 1'b1, 8'd0, 3'd0);   // c3 code 0x05: no hit
        observe(1'b0, 16'h1200, 3'd2, 1'b1, 8'd0, 3'd0);   // c1 now write counter: no hit
        observe(1'b0, 16'h0000, 3'd1, 1'b0, 8'd0, 3'd0);   // c2 read counter hit
        evt_code = {8'h41, 8'h42, 8'h41};

        // R10: same-cycle write and observation
        observe_with_write(8'h54, 32'hFFFF_5555, 1'b0, 16'h12AA, 3'd2, 1'b1); // old word hits
        observe(1'b0, 16'h12AA, 3'd2, 1'b1, 8'd0, 3'd0);                      // new word misses
        observe_with_write(8'h60, 32'h0000_0006, 1'b1, 16'h0001, 3'd3, 1'b0); // old select hits c2
        observe(1'b1, 16'h0001, 3'd3, 1'b0, 8'd0, 3'd0);                      // now misses
        check_all_regs("R10");

        // R9: back-to-back then idle
        observe(1'b0, 16'h5555, 3'd2, 1'b1, 8'd0, 3'd0);
        observe(1'b0, 16'h5555, 3'd2, 1'b1, 8'd0, 3'd0);
        check_idle("R9");
        check_idle("R9");

        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R9 pending results actual %0d expected 0", sb_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule